// File: doc/BRIEF.md
# Interrupt Posting Engine

This block sits in an I/O memory-management unit and handles interrupt requests raised by devices that have been assigned to guests. Every request names an entry in a small remapping table. An entry whose posting bit is clear is a plain remapped interrupt: the engine sends the entry's vector and destination out on the remap output. An entry whose posting bit is set is handled in posted form. The engine locks the posted-interrupt descriptor that the entry points to. It records the guest vector in that descriptor's 256-bit pending field. It then decides from three flags whether the target CPU must be notified: outstanding, suppress and urgent.

A notification carries the descriptor's notification vector and destination CPU. Software loads the table and the descriptors through write ports and can read any descriptor back. A software write that targets the descriptor currently under lock is held off until the lock is released, so each posted update is atomic. Requests that name a slot past the end of the table, or an entry that is not present, are dropped and reported with a one-cycle fault pulse.

Top module: `irq_post_engine`

## Requirements
- R1: When the addressed entry is present and its posting bit is 0, `rmp_valid` pulses for exactly one cycle, starting one clock after the accepting edge. During that cycle `rmp_vec` and `rmp_dst` show the entry's vector and destination, and no descriptor changes.
- R2: A request whose index is at or above the table depth, or whose entry has its present bit at 0, pulses `fault` for one cycle, starting one clock after the accepting edge. It produces no other output and changes no descriptor. At most one of `rmp_valid`, `ntf_valid` and `fault` is high in any cycle.
- R3: Every posted request sets bit number `vec` of the target descriptor's pending field. It sets the bit whether or not a notification follows, and it leaves every other pending bit unchanged.
- R4: A posted request produces a notification only if the descriptor's outstanding flag is 0 and either the entry's urgent flag is 1 or the descriptor's suppress flag is 0. When a notification is produced, the outstanding flag is set to 1 in the same update. Otherwise the flags are unchanged.
- R5: A notification is a one-cycle pulse on `ntf_valid` that starts three clocks after the accepting edge. It carries the descriptor's notification vector on `ntf_vec` and its destination CPU on `ntf_dst`, both as they stood when the locked descriptor was read.
- R6: `req_ready` is 1 in the idle state and falls after an accepting edge. It stays low for 1 cycle on a remapped or dropped request, and for 3 cycles on a posted request, which covers lookup, lock, read and update.
- R7: While a descriptor is locked, `dw_ready` is 0 for a software write to that descriptor, and the write takes effect only after the lock is released. Writes to other descriptors are accepted at once.
- R8: The lock is released at the end of every posted update, whether or not a notification was sent. From then on both `req_ready` and `dw_ready` are 1 again.
- R9: An accepted software descriptor write loads the notification vector, destination CPU, suppress flag and outstanding flag. It clears the whole pending field when `dw_clr_pir` is 1. `dr_*` always shows the descriptor selected by `dr_idx`.
- R10: After reset, `req_ready` is 1. All pulse outputs are 0, every table entry is not present, and every descriptor field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Interrupt request present |
| req_ready | output | 1 | Engine can accept a request |
| req_idx | input | IDX_W | Remapping table index of the request |
| tw_en | input | 1 | Table entry write strobe |
| tw_idx | input | IDX_W | Entry to write |
| tw_present | input | 1 | Entry present bit |
| tw_post | input | 1 | Posting bit: 1 posts, 0 remaps |
| tw_urgent | input | 1 | Urgent flag of a posted entry |
| tw_vec | input | 8 | Remap vector, or guest vector when posted |
| tw_dst | input | DST_W | Remap destination CPU |
| tw_pd | input | PD_W | Descriptor index of a posted entry |
| dw_valid | input | 1 | Descriptor write request |
| dw_ready | output | 1 | Descriptor write may proceed |
| dw_idx | input | PD_W | Descriptor to write |
| dw_nv | input | 8 | Notification vector |
| dw_ndst | input | DST_W | Notification destination CPU |
| dw_sn | input | 1 | Suppress flag |
| dw_on | input | 1 | Outstanding flag |
| dw_clr_pir | input | 1 | Clear the pending field |
| dr_idx | input | PD_W | Descriptor selected for read-back |
| dr_pir | output | 256 | Pending field of selected descriptor |
| dr_on | output | 1 | Outstanding flag of selected descriptor |
| dr_sn | output | 1 | Suppress flag of selected descriptor |
| dr_nv | output | 8 | Notification vector of selected descriptor |
| dr_ndst | output | DST_W | Destination CPU of selected descriptor |
| rmp_valid | output | 1 | Remapped interrupt pulse |
| rmp_vec | output | 8 | Remapped vector |
| rmp_dst | output | DST_W | Remapped destination |
| ntf_valid | output | 1 | Notification event pulse |
| ntf_vec | output | 8 | Notification vector |
| ntf_dst | output | DST_W | Notification destination CPU |
| fault | output | 1 | Dropped-request pulse |

## Verification
The bench builds the engine with a table depth of 6 behind a 3-bit index, so indices 6 and 7 reach the out-of-range fault path. Four descriptors let the bench send a software write to one descriptor while a different one is locked. With an 8-bit destination width, the bench can tell a notification's vector and destination apart from those of a remapped interrupt. The pending-field positions used are 0, 0x40, 0x80 and 0xFF, which cover both ends of the 256-bit field.

// File: rtl/irq_post_pkg.sv
package irq_post_pkg;
  localparam int VEC_W = 8;
  localparam int PIR_W = 1 << VEC_W;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_READ, ST_UPD} post_st_e;

  // Notify unless one is already outstanding; suppression yields to urgency.
  function automatic logic notify_needed(input logic on, input logic sn, input logic urg);
    return !on && (urg || !sn);
  endfunction

  function automatic logic [PIR_W-1:0] pir_with_bit(input logic [PIR_W-1:0] pir,
                                                     input logic [VEC_W-1:0] vec);
    logic [PIR_W-1:0] r;
    r = pir;
    r[vec] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/irq_post_table.sv
module irq_post_table
  import irq_post_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int IDX_W = 3,
  parameter int DST_W = 8,
  parameter int PD_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_present,
  input  logic             wr_post,
  input  logic             wr_urgent,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic [DST_W-1:0] wr_dst,
  input  logic [PD_W-1:0]  wr_pd,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_hit,
  output logic             rd_post,
  output logic             rd_urgent,
  output logic [VEC_W-1:0] rd_vec,
  output logic [DST_W-1:0] rd_dst,
  output logic [PD_W-1:0]  rd_pd
);
  logic             e_present [DEPTH];
  logic             e_post    [DEPTH];
  logic             e_urgent  [DEPTH];
  logic [VEC_W-1:0] e_vec     [DEPTH];
  logic [DST_W-1:0] e_dst     [DEPTH];
  logic [PD_W-1:0]  e_pd      [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_present[g] <= 1'b0;
        e_post[g]    <= 1'b0;
        e_urgent[g]  <= 1'b0;
        e_vec[g]     <= '0;
        e_dst[g]     <= '0;
        e_pd[g]      <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        e_present[g] <= wr_present;
        e_post[g]    <= wr_post;
        e_urgent[g]  <= wr_urgent;
        e_vec[g]     <= wr_vec;
        e_dst[g]     <= wr_dst;
        e_pd[g]      <= wr_pd;
      end
    end
  end

  // Select by compare so an index past the depth simply misses.
  always_comb begin
    rd_hit    = 1'b0;
    rd_post   = 1'b0;
    rd_urgent = 1'b0;
    rd_vec    = '0;
    rd_dst    = '0;
    rd_pd     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_hit    = e_present[i];
        rd_post   = e_post[i];
        rd_urgent = e_urgent[i];
        rd_vec    = e_vec[i];
        rd_dst    = e_dst[i];
        rd_pd     = e_pd[i];
      end
    end
  end
endmodule

// File: rtl/irq_post_desc.sv
module irq_post_desc
  import irq_post_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PD_W  = 2,
  parameter int DST_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_valid,
  output logic             sw_ready,
  input  logic [PD_W-1:0]  sw_idx,
  input  logic [VEC_W-1:0] sw_nv,
  input  logic [DST_W-1:0] sw_ndst,
  input  logic             sw_sn,
  input  logic             sw_on,
  input  logic             sw_clr,
  input  logic [PD_W-1:0]  sw_rd_idx,
  output logic [PIR_W-1:0] sw_rd_pir,
  output logic             sw_rd_on,
  output logic             sw_rd_sn,
  output logic [VEC_W-1:0] sw_rd_nv,
  output logic [DST_W-1:0] sw_rd_ndst,
  input  logic             lock_active,
  input  logic [PD_W-1:0]  lock_pd,
  output logic             lk_on,
  output logic             lk_sn,
  output logic [VEC_W-1:0] lk_nv,
  output logic [DST_W-1:0] lk_ndst,
  input  logic             upd_en,
  input  logic [VEC_W-1:0] upd_vec,
  input  logic             upd_set_on
);
  logic [PIR_W-1:0] d_pir  [DEPTH];
  logic             d_on   [DEPTH];
  logic             d_sn   [DEPTH];
  logic [VEC_W-1:0] d_nv   [DEPTH];
  logic [DST_W-1:0] d_ndst [DEPTH];

  // Software is held off the descriptor currently under lock.
  assign sw_ready = !(lock_active && sw_idx == lock_pd);

  for (genvar g = 0; g < DEPTH; g++) begin : g_desc
    logic sw_hit, upd_hit;
    assign sw_hit  = sw_valid && sw_ready && sw_idx == PD_W'(g);
    assign upd_hit = upd_en && lock_pd == PD_W'(g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_pir[g]  <= '0;
        d_on[g]   <= 1'b0;
        d_sn[g]   <= 1'b0;
        d_nv[g]   <= '0;
        d_ndst[g] <= '0;
      end else if (sw_hit) begin
        d_on[g]   <= sw_on;
        d_sn[g]   <= sw_sn;
        d_nv[g]   <= sw_nv;
        d_ndst[g] <= sw_ndst;
        if (sw_clr) d_pir[g] <= '0;
      end else if (upd_hit) begin
        d_pir[g] <= pir_with_bit(d_pir[g], upd_vec);
        if (upd_set_on) d_on[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    sw_rd_pir  = '0;
    sw_rd_on   = 1'b0;
    sw_rd_sn   = 1'b0;
    sw_rd_nv   = '0;
    sw_rd_ndst = '0;
    lk_on      = 1'b0;
    lk_sn      = 1'b0;
    lk_nv      = '0;
    lk_ndst    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sw_rd_idx == PD_W'(i)) begin
        sw_rd_pir  = d_pir[i];
        sw_rd_on   = d_on[i];
        sw_rd_sn   = d_sn[i];
        sw_rd_nv   = d_nv[i];
        sw_rd_ndst = d_ndst[i];
      end
      if (lock_pd == PD_W'(i)) begin
        lk_on   = d_on[i];
        lk_sn   = d_sn[i];
        lk_nv   = d_nv[i];
        lk_ndst = d_ndst[i];
      end
    end
  end
endmodule

// File: rtl/irq_post_ctrl.sv
module irq_post_ctrl
  import irq_post_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int DST_W = 8,
  parameter int PD_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_idx,
  output logic [IDX_W-1:0] look_idx,
  input  logic             ent_hit,
  input  logic             ent_post,
  input  logic             ent_urgent,
  input  logic [VEC_W-1:0] ent_vec,
  input  logic [DST_W-1:0] ent_dst,
  input  logic [PD_W-1:0]  ent_pd,
  output logic             lock_active,
  output logic [PD_W-1:0]  lock_pd,
  input  logic             lk_on,
  input  logic             lk_sn,
  input  logic [VEC_W-1:0] lk_nv,
  input  logic [DST_W-1:0] lk_ndst,
  output logic             upd_evt,
  output logic [VEC_W-1:0] upd_vec,
  output logic             notify_ok,
  output logic             rmp_valid,
  output logic [VEC_W-1:0] rmp_vec,
  output logic [DST_W-1:0] rmp_dst,
  output logic             ntf_valid,
  output logic [VEC_W-1:0] ntf_vec,
  output logic [DST_W-1:0] ntf_dst,
  output logic             fault
);
  post_st_e         st;
  logic             urg_q, on_q, sn_q;
  logic [VEC_W-1:0] nv_q;
  logic [DST_W-1:0] ndst_q;

  assign req_ready = (st == ST_IDLE);
  assign upd_evt   = (st == ST_UPD);
  assign notify_ok = upd_evt && notify_needed(on_q, sn_q, urg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      look_idx    <= '0;
      lock_active <= 1'b0;
      lock_pd     <= '0;
      upd_vec     <= '0;
      urg_q       <= 1'b0;
      on_q        <= 1'b0;
      sn_q        <= 1'b0;
      nv_q        <= '0;
      ndst_q      <= '0;
      rmp_valid   <= 1'b0;
      rmp_vec     <= '0;
      rmp_dst     <= '0;
      ntf_valid   <= 1'b0;
      ntf_vec     <= '0;
      ntf_dst     <= '0;
      fault       <= 1'b0;
    end else begin
      rmp_valid <= 1'b0;
      ntf_valid <= 1'b0;
      fault     <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          look_idx <= req_idx;
          st       <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!ent_hit) begin
            fault <= 1'b1;
            st    <= ST_IDLE;
          end else if (!ent_post) begin
            rmp_valid <= 1'b1;
            rmp_vec   <= ent_vec;
            rmp_dst   <= ent_dst;
            st        <= ST_IDLE;
          end else begin
            // Lock first; descriptor fields are read in the next state.
            lock_active <= 1'b1;
            lock_pd     <= ent_pd;
            upd_vec     <= ent_vec;
            urg_q       <= ent_urgent;
            st          <= ST_READ;
          end
        end
        ST_READ: begin
          on_q   <= lk_on;
          sn_q   <= lk_sn;
          nv_q   <= lk_nv;
          ndst_q <= lk_ndst;
          st     <= ST_UPD;
        end
        ST_UPD: begin
          ntf_valid   <= notify_ok;
          ntf_vec     <= nv_q;
          ntf_dst     <= ndst_q;
          lock_active <= 1'b0;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_post_engine.sv
module irq_post_engine
  import irq_post_pkg::*;
#(
  parameter int TBL_DEPTH = 6,
  parameter int IDX_W     = 3,
  parameter int PD_DEPTH  = 4,
  parameter int PD_W      = 2,
  parameter int DST_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             tw_en,
  input  logic [IDX_W-1:0] tw_idx,
  input  logic             tw_present,
  input  logic             tw_post,
  input  logic             tw_urgent,
  input  logic [7:0]       tw_vec,
  input  logic [DST_W-1:0] tw_dst,
  input  logic [PD_W-1:0]  tw_pd,
  input  logic             dw_valid,
  output logic             dw_ready,
  input  logic [PD_W-1:0]  dw_idx,
  input  logic [7:0]       dw_nv,
  input  logic [DST_W-1:0] dw_ndst,
  input  logic             dw_sn,
  input  logic             dw_on,
  input  logic             dw_clr_pir,
  input  logic [PD_W-1:0]  dr_idx,
  output logic [255:0]     dr_pir,
  output logic             dr_on,
  output logic             dr_sn,
  output logic [7:0]       dr_nv,
  output logic [DST_W-1:0] dr_ndst,
  output logic             rmp_valid,
  output logic [7:0]       rmp_vec,
  output logic [DST_W-1:0] rmp_dst,
  output logic             ntf_valid,
  output logic [7:0]       ntf_vec,
  output logic [DST_W-1:0] ntf_dst,
  output logic             fault
);
  logic [IDX_W-1:0] look_idx;
  logic             ent_hit, ent_post, ent_urgent;
  logic [VEC_W-1:0] ent_vec;
  logic [DST_W-1:0] ent_dst;
  logic [PD_W-1:0]  ent_pd;
  logic             lock_active;
  logic [PD_W-1:0]  lock_pd;
  logic             lk_on, lk_sn;
  logic [VEC_W-1:0] lk_nv;
  logic [DST_W-1:0] lk_ndst;
  logic             upd_evt, notify_ok;
  logic [VEC_W-1:0] upd_vec;

  irq_post_table #(.DEPTH(TBL_DEPTH), .IDX_W(IDX_W), .DST_W(DST_W), .PD_W(PD_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tw_en), .wr_idx(tw_idx), .wr_present(tw_present), .wr_post(tw_post),
    .wr_urgent(tw_urgent), .wr_vec(tw_vec), .wr_dst(tw_dst), .wr_pd(tw_pd),
    .rd_idx(look_idx), .rd_hit(ent_hit), .rd_post(ent_post), .rd_urgent(ent_urgent),
    .rd_vec(ent_vec), .rd_dst(ent_dst), .rd_pd(ent_pd)
  );

  irq_post_desc #(.DEPTH(PD_DEPTH), .PD_W(PD_W), .DST_W(DST_W)) u_desc (
    .clk(clk), .rst_n(rst_n),
    .sw_valid(dw_valid), .sw_ready(dw_ready), .sw_idx(dw_idx), .sw_nv(dw_nv),
    .sw_ndst(dw_ndst), .sw_sn(dw_sn), .sw_on(dw_on), .sw_clr(dw_clr_pir),
    .sw_rd_idx(dr_idx), .sw_rd_pir(dr_pir), .sw_rd_on(dr_on), .sw_rd_sn(dr_sn),
    .sw_rd_nv(dr_nv), .sw_rd_ndst(dr_ndst),
    .lock_active(lock_active), .lock_pd(lock_pd),
    .lk_on(lk_on), .lk_sn(lk_sn), .lk_nv(lk_nv), .lk_ndst(lk_ndst),
    .upd_en(upd_evt), .upd_vec(upd_vec), .upd_set_on(notify_ok)
  );

  irq_post_ctrl #(.IDX_W(IDX_W), .DST_W(DST_W), .PD_W(PD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .look_idx(look_idx), .ent_hit(ent_hit), .ent_post(ent_post),
    .ent_urgent(ent_urgent), .ent_vec(ent_vec), .ent_dst(ent_dst), .ent_pd(ent_pd),
    .lock_active(lock_active), .lock_pd(lock_pd),
    .lk_on(lk_on), .lk_sn(lk_sn), .lk_nv(lk_nv), .lk_ndst(lk_ndst),
    .upd_evt(upd_evt), .upd_vec(upd_vec), .notify_ok(notify_ok),
    .rmp_valid(rmp_valid), .rmp_vec(rmp_vec), .rmp_dst(rmp_dst),
    .ntf_valid(ntf_valid), .ntf_vec(ntf_vec), .ntf_dst(ntf_dst), .fault(fault)
  );
endmodule

// File: rtl/irq_post_chk.sv
module irq_post_chk #(
  parameter int PD_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            dw_ready,
  input logic [PD_W-1:0] dw_idx,
  input logic            lock_active,
  input logic [PD_W-1:0] lock_pd,
  input logic            upd_evt,
  input logic            rmp_valid,
  input logic            ntf_valid,
  input logic            fault
);
  assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |-> !req_ready);

  assert_accept_drops_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_sw_stall_on_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && dw_idx == lock_pd) |-> !dw_ready);

  assert_lock_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (!lock_active && req_ready));

  assert_single_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rmp_valid, ntf_valid, fault}));

  assert_ntf_follows_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> $past(upd_evt));
endmodule

bind irq_post_engine irq_post_chk #(.PD_W(PD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .dw_ready(dw_ready), .dw_idx(dw_idx), .lock_active(lock_active), .lock_pd(lock_pd),
  .upd_evt(upd_evt), .rmp_valid(rmp_valid), .ntf_valid(ntf_valid), .fault(fault)
);

// File: tb/test_irq_post_engine.sv
`timescale 1ns/1ps
module test_irq_post_engine;
  localparam int TD = 6, IW = 3, PDD = 4, PW = 2, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready;
  logic [IW-1:0] req_idx = '0;
  logic tw_en = 0, tw_present = 0, tw_post = 0, tw_urgent = 0;
  logic [IW-1:0] tw_idx = '0;
  logic [7:0] tw_vec = '0;
  logic [DW-1:0] tw_dst = '0;
  logic [PW-1:0] tw_pd = '0;
  logic dw_valid = 0, dw_ready, dw_sn = 0, dw_on = 0, dw_clr_pir = 0;
  logic [PW-1:0] dw_idx = '0, dr_idx = '0;
  logic [7:0] dw_nv = '0;
  logic [DW-1:0] dw_ndst = '0;
  logic [255:0] dr_pir;
  logic dr_on, dr_sn;
  logic [7:0] dr_nv;
  logic [DW-1:0] dr_ndst;
  logic rmp_valid, ntf_valid, fault;
  logic [7:0] rmp_vec, ntf_vec;
  logic [DW-1:0] rmp_dst, ntf_dst;

  always #4 clk = ~clk;

  irq_post_engine #(.TBL_DEPTH(TD), .IDX_W(IW), .PD_DEPTH(PDD), .PD_W(PW), .DST_W(DW)) i_irq_post_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_present(tw_present), .tw_post(tw_post),
    .tw_urgent(tw_urgent), .tw_vec(tw_vec), .tw_dst(tw_dst), .tw_pd(tw_pd),
    .dw_valid(dw_valid), .dw_ready(dw_ready), .dw_idx(dw_idx), .dw_nv(dw_nv),
    .dw_ndst(dw_ndst), .dw_sn(dw_sn), .dw_on(dw_on), .dw_clr_pir(dw_clr_pir),
    .dr_idx(dr_idx), .dr_pir(dr_pir), .dr_on(dr_on), .dr_sn(dr_sn), .dr_nv(dr_nv),
    .dr_ndst(dr_ndst), .rmp_valid(rmp_valid), .rmp_vec(rmp_vec), .rmp_dst(rmp_dst),
    .ntf_valid(ntf_valid), .ntf_vec(ntf_vec), .ntf_dst(ntf_dst), .fault(fault)
  );

  // Bench model: kind 0 remap, 1 notify, 2 fault
  typedef struct packed { logic [1:0] kind; logic [7:0] vec; logic [7:0] dst; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic t_pres [TD], t_post [TD], t_urg [TD];
  logic [7:0] t_vec [TD], t_dst [TD];
  int t_pd [TD];
  logic m_on [PDD], m_sn [PDD];
  logic [7:0] m_nv [PDD], m_ndst [PDD];
  logic [255:0] m_pir [PDD];

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever an output pulse shows up
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (rmp_valid || ntf_valid || fault)) begin
        item_t got, e;
        got.kind = rmp_valid ? 2'd0 : (ntf_valid ? 2'd1 : 2'd2);
        got.vec  = rmp_valid ? rmp_vec : (ntf_valid ? ntf_vec : 8'h0);
        got.dst  = rmp_valid ? rmp_dst : (ntf_valid ? ntf_dst : 8'h0);
        chk($onehot({rmp_valid, ntf_valid, fault}), "R2 single pulse",
            {rmp_valid, ntf_valid, fault}, 3'b0);
        if (exp_q.size() == 0) chk(0, "R1/R2/R4 unexpected output", got, 0);
        else begin
          e = exp_q.pop_front();
          chk(got == e, "R1/R4/R5 output item", got, e);
        end
      end
    end
  end

  task automatic tbl_write(input int i, input bit pr, input bit po, input bit ur,
                           input logic [7:0] v, input logic [7:0] d, input int pd);
    @(negedge clk);
    tw_en = 1; tw_idx = IW'(i); tw_present = pr; tw_post = po; tw_urgent = ur;
    tw_vec = v; tw_dst = d; tw_pd = PW'(pd);
    @(posedge clk); #1 tw_en = 0;
    t_pres[i] = pr; t_post[i] = po; t_urg[i] = ur; t_vec[i] = v; t_dst[i] = d; t_pd[i] = pd;
  endtask

  task automatic desc_write(input int i, input logic [7:0] nv, input logic [7:0] nd,
                            input bit sn, input bit on, input bit clr);
    @(negedge clk);
    dw_valid = 1; dw_idx = PW'(i); dw_nv = nv; dw_ndst = nd; dw_sn = sn; dw_on = on; dw_clr_pir = clr;
    while (!dw_ready) @(negedge clk);
    @(posedge clk); #1 dw_valid = 0;
    m_nv[i] = nv; m_ndst[i] = nd; m_sn[i] = sn; m_on[i] = on;
    if (clr) m_pir[i] = '0;
  endtask

  task automatic check_desc(input string req);
    for (int i = 0; i < PDD; i++) begin
      dr_idx = PW'(i); #1;
      chk(dr_pir == m_pir[i], req, dr_pir, m_pir[i]);
      chk({dr_on, dr_sn, dr_nv, dr_ndst} == {m_on[i], m_sn[i], m_nv[i], m_ndst[i]}, req,
          {dr_on, dr_sn, dr_nv, dr_ndst}, {m_on[i], m_sn[i], m_nv[i], m_ndst[i]});
    end
  endtask

  // Model the request, push the expected item, then drive it
  task automatic model_req(input int i, output int lat);
    item_t e;
    if (i >= TD || !t_pres[i]) begin
      e = '{2'd2, 8'h0, 8'h0}; exp_q.push_back(e); lat = 1;
    end else if (!t_post[i]) begin
      e = '{2'd0, t_vec[i], t_dst[i]}; exp_q.push_back(e); lat = 1;
    end else begin
      int p = t_pd[i];
      m_pir[p][t_vec[i]] = 1'b1;
      if (!m_on[p] && (t_urg[i] || !m_sn[p])) begin
        e = '{2'd1, m_nv[p], m_ndst[p]}; exp_q.push_back(e);
        m_on[p] = 1'b1;
      end
      lat = 3;
    end
  endtask

  task automatic send_req(input int i, input string req);
    int lat, n;
    model_req(i, lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_idx = IW'(i);
    @(posedge clk); #1 req_valid = 0;
    n = 0;
    @(negedge clk);
    while (!req_ready) begin n++; @(negedge clk); end
    chk(n == lat, "R6 busy cycles", n, lat);
    check_desc(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TD; i++) begin
      t_pres[i] = 0; t_post[i] = 0; t_urg[i] = 0; t_vec[i] = 0; t_dst[i] = 0; t_pd[i] = 0;
    end
    for (int i = 0; i < PDD; i++) begin
      m_on[i] = 0; m_sn[i] = 0; m_nv[i] = 0; m_ndst[i] = 0; m_pir[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1, "R10 ready", req_ready, 1);
    chk({rmp_valid, ntf_valid, fault} == 0, "R10 pulses", {rmp_valid, ntf_valid, fault}, 0);
    check_desc("R10 descriptors");
    send_req(2, "R10 entry absent");

    tbl_write(0, 1, 0, 0, 8'h31, 8'h05, 0);
    tbl_write(1, 1, 1, 0, 8'h40, 8'h00, 1);
    tbl_write(2, 1, 1, 1, 8'hFF, 8'h00, 1);
    tbl_write(3, 1, 1, 0, 8'h00, 8'h00, 2);
    tbl_write(4, 0, 1, 0, 8'h12, 8'h00, 0);
    tbl_write(5, 1, 1, 1, 8'h80, 8'h00, 3);
    desc_write(1, 8'hE0, 8'h03, 0, 0, 0);
    desc_write(2, 8'hE1, 8'h07, 1, 0, 0);
    desc_write(3, 8'hE2, 8'h09, 1, 0, 0);
    check_desc("R9 descriptor write");

    send_req(0, "R1 remap");
    send_req(6, "R2 index past depth");
    send_req(7, "R2 index max");
    send_req(4, "R2 not present");
    send_req(1, "R3 R4 first post notifies");
    send_req(2, "R3 R4 outstanding blocks notify");
    desc_write(1, 8'hE0, 8'h03, 0, 0, 0);
    send_req(2, "R4 urgent after clear");
    send_req(3, "R3 R4 suppressed no notify");
    send_req(5, "R4 urgent overrides suppress");

    // R7/R8: software write against the locked descriptor
    desc_write(2, 8'hE1, 8'h07, 0, 0, 0);
    begin
      int lat;
      model_req(3, lat);
      @(negedge clk);
      req_valid = 1; req_idx = 3'd3;
      @(posedge clk); #1 req_valid = 0;
      @(posedge clk);
      @(negedge clk);
      chk(req_ready == 0, "R6 low while locked", req_ready, 0);
      dw_idx = 2'd1; #1;
      chk(dw_ready == 1, "R7 other descriptor writable", dw_ready, 1);
      dw_idx = 2'd2; dw_nv = 8'h55; dw_ndst = 8'h11; dw_sn = 1; dw_on = 0; dw_clr_pir = 0;
      dw_valid = 1; #1;
      chk(dw_ready == 0, "R7 locked descriptor stalls", dw_ready, 0);
      @(negedge clk);
      chk(dw_ready == 0, "R7 still stalled", dw_ready, 0);
      @(negedge clk);
      chk(dw_ready == 1, "R8 lock released", dw_ready, 1);
      chk(req_ready == 1, "R8 ready restored", req_ready, 1);
      @(posedge clk); #1 dw_valid = 0;
      m_nv[2] = 8'h55; m_ndst[2] = 8'h11; m_sn[2] = 1; m_on[2] = 0;
      check_desc("R7 write applied after release");
    end

    desc_write(1, 8'hE0, 8'h03, 0, 0, 1);
    check_desc("R9 pending clear");
    send_req(5, "R3 R4 outstanding on pd3");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all expected outputs seen", exp_q.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule